// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frames from a word-wide streaming input into host memory buffers. A ring of descriptors in memory tells it where each buffer is and how large it is. For each frame the engine reads a descriptor through a single request/grant memory port and checks that the descriptor is handed to hardware. It then copies the frame words into the buffer, writes back a completion code and two byte counts, and follows the descriptor's link to the next one.

When the current descriptor is not handed to hardware, the engine stops on it and does not move on. Frames that keep arriving are held in a small local staging RAM. When that RAM overflows, a sticky flag is raised. Software restarts the engine by writing the control word with the enable bit set. The engine then continues at the descriptor after the one it stopped on and never re-reads the abandoned one. Software reads the current and next descriptor pointers to find where reception resumed.

Top module: `rx_desc_dma`

## Requirements
- R1: A descriptor is eight 32-bit words at a 32-byte aligned address. The engine reads bytes 0, 4, 8 and 12 as buffer address, buffer size in bytes, next-descriptor address and command/status.
- R2: A descriptor is filled only when command/status bits 31:28 equal 0xA. Otherwise the engine halts on it: no memory request, the current pointer is unchanged, and status word 0 bit 1 (chain end) is set if control bit 1 is 1.
- R3: Frame word k is written to buffer address + 4k in arrival order. Words beyond buffer size / 4 are discarded.
- R4: With control bit 0 set, completion writes descriptor byte 12 = {0x4, command bits 27:0}, byte 16 = received bytes (4 per word) and byte 20 = stored bytes. With control bit 0 clear, no descriptor word is written.
- R5: After each descriptor the current pointer (register 1) takes the link value. Register 2 always shows the link word of the last fetched descriptor.
- R6: Writing register 0 with bit 31 set while halted resumes at the link of the halted descriptor. The halted descriptor is not fetched again.
- R7: Frames arriving while halted are held in a STAGE_DEPTH-word staging RAM and delivered after resume. A word arriving while it is full is dropped and sets status word 1 bit 1, which also reads as status word 0 bit 2.
- R8: Status word 0 bit 0 (frame done) is set only when a descriptor with command bit 23 set completes.
- R9: Status bits (register 3 and register 4) are sticky and clear when 1 is written to them. irq is the OR of register 3 bits ANDed with mask register 5, one clock after the status.
- R10: A memory request keeps its address, direction and data until mem_gnt. Read data is taken in the cycle after the grant.
- R11: With control bit 31 clear, no descriptor fetch starts.
- R12: After reset all registers read zero. The current pointer can be written through register 1 while the engine is idle or halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rx_valid | input | 1 | Frame word valid |
| rx_data | input | 32 | Frame word |
| rx_last | input | 1 | Last word of frame |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read grant |
| irq | output | 1 | Masked interrupt |

## Verification
A register write takes effect at the next clock edge. A status event appears in the status registers one edge after the engine step that causes it, and irq follows one edge later. The bench therefore reads status and irq at least two falling edges after a write or an event. Memory writes land one edge after their grant. The grant is random, so completion time varies. The bench polls its memory model until the descriptor's completion code appears, or waits a fixed settle window when writeback is off, and then lets a further settle window pass before comparing buffers, counts and pointers.

// File: rtl/rxdr_pkg.sv
package rxdr_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_RD, ST_RDW, ST_CHK, ST_XFER, ST_WB, ST_DONE, ST_HALT
   } eng_state_t;

   localparam logic [3:0] OWN_HW      = 4'hA;
   localparam logic [3:0] CODE_FEND   = 4'h4;
   localparam int         CMD_FLAG    = 23;

   localparam logic [2:0] RA_CTRL  = 3'd0;
   localparam logic [2:0] RA_CUR   = 3'd1;
   localparam logic [2:0] RA_NXT   = 3'd2;
   localparam logic [2:0] RA_STAT0 = 3'd3;
   localparam logic [2:0] RA_STAT1 = 3'd4;
   localparam logic [2:0] RA_MASK  = 3'd5;

   localparam int CTRL_EN   = 31;
   localparam int CTRL_CHIE = 1;
   localparam int CTRL_WB   = 0;
endpackage

// File: rtl/rxdr_stage_fifo.sv
module rxdr_stage_fifo #(
   parameter int W     = 33,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         overflow,
   output logic         out_valid,
   output logic [W-1:0] out_data,
   input  logic         pop
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = PW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rxdr_stage_fifo: DEPTH must be a power of two >= 2");
      end
   endgenerate

   logic [W-1:0]  mem_q [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          full, push, take;

   assign full      = (cnt_q == CW'(DEPTH));
   assign push      = in_valid && !full;
   assign overflow  = in_valid && full;
   assign out_valid = (cnt_q != '0);
   assign take      = pop && out_valid;
   assign out_data  = mem_q[rp_q];

   always_ff @(posedge clk) begin
      if (push) mem_q[wp_q] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (take) rp_q <= rp_q + 1'b1;
         case ({push, take})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/rxdr_regs.sv
module rxdr_regs
   import rxdr_pkg::*;
#(
   parameter int AW      = 32,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    addr,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata,
   input  logic [AW-1:0] cur_ptr,
   input  logic [AW-1:0] nxt_ptr,
   input  logic          ev_fdone,
   input  logic          ev_chend,
   input  logic          ev_ramfull,
   output logic          ctrl_en,
   output logic          ctrl_chie,
   output logic          ctrl_wb,
   output logic          restart,
   output logic          cur_load,
   output logic          err_flag,
   output logic          irq
);
   logic       en_q, chie_q, wb_q;
   logic [2:0] mask_q;
   logic       fdone_q, chend_q, ramfull_q;
   logic       w_ctrl, w_s0, w_s1, w_mask;
   logic       irq_raw;
   logic       unused_wdata;

   assign unused_wdata = ^wdata[30:3];

   assign w_ctrl   = wr_en && (addr == RA_CTRL);
   assign cur_load = wr_en && (addr == RA_CUR);
   assign w_s0     = wr_en && (addr == RA_STAT0);
   assign w_s1     = wr_en && (addr == RA_STAT1);
   assign w_mask   = wr_en && (addr == RA_MASK);
   assign restart  = w_ctrl && wdata[CTRL_EN];

   assign ctrl_en   = en_q;
   assign ctrl_chie = chie_q;
   assign ctrl_wb   = wb_q;
   assign err_flag  = ramfull_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         chie_q    <= 1'b0;
         wb_q      <= 1'b0;
         mask_q    <= '0;
         fdone_q   <= 1'b0;
         chend_q   <= 1'b0;
         ramfull_q <= 1'b0;
      end else begin
         if (w_ctrl) begin
            en_q   <= wdata[CTRL_EN];
            chie_q <= wdata[CTRL_CHIE];
            wb_q   <= wdata[CTRL_WB];
         end
         if (w_mask) mask_q <= wdata[2:0];
         fdone_q   <= (fdone_q   & ~(w_s0 & wdata[0])) | ev_fdone;
         chend_q   <= (chend_q   & ~(w_s0 & wdata[1])) | ev_chend;
         ramfull_q <= (ramfull_q & ~(w_s1 & wdata[1])) | ev_ramfull;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         RA_CTRL:  rdata = {en_q, 29'd0, chie_q, wb_q};
         RA_CUR:   rdata = 32'(cur_ptr);
         RA_NXT:   rdata = 32'(nxt_ptr);
         RA_STAT0: rdata = {29'd0, ramfull_q, chend_q, fdone_q};
         RA_STAT1: rdata = {30'd0, ramfull_q, 1'b0};
         RA_MASK:  rdata = {29'd0, mask_q};
         default:  rdata = '0;
      endcase
   end

   assign irq_raw = |(mask_q & {ramfull_q, chend_q, fdone_q});

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate
endmodule

// File: rtl/rxdr_engine.sv
module rxdr_engine
   import rxdr_pkg::*;
#(
   parameter int AW    = 32,
   parameter int LEN_W = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_en,
   input  logic          ctrl_chie,
   input  logic          ctrl_wb,
   input  logic          restart,
   input  logic          cur_load,
   input  logic [AW-1:0] cur_wdata,
   output logic [AW-1:0] cur_ptr,
   output logic [AW-1:0] nxt_ptr,
   output logic          halted,
   input  logic          in_valid,
   input  logic [31:0]   in_data,
   input  logic          in_last,
   output logic          pop,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_gnt,
   input  logic [31:0]   mem_rdata,
   output logic          ev_fdone,
   output logic          ev_chend
);
   localparam int BW = AW - 2;

   eng_state_t       state;
   logic [2:0]       widx;
   logic [AW-1:0]    cur_q, nxt_q, buf_q;
   logic [BW-1:0]    bwords_q;
   logic [31:0]      cmd_q;
   logic [LEN_W-1:0] rcnt_q, scnt_q;
   logic             room, owned, xfer_take;
   logic [AW-1:0]    desc_word;
   logic [31:0]      rbytes, sbytes;
   logic             unused_rd;

   assign unused_rd = ^mem_rdata[1:0];

   assign room      = {{(BW - LEN_W){1'b0}}, scnt_q} < bwords_q;
   assign owned     = (cmd_q[31:28] == OWN_HW);
   assign xfer_take = (state == ST_XFER) && in_valid;
   assign pop       = xfer_take && (!room || mem_gnt);
   assign desc_word = cur_q + AW'({widx, 2'b00});
   assign rbytes    = 32'({rcnt_q, 2'b00});
   assign sbytes    = 32'({scnt_q, 2'b00});

   assign cur_ptr  = cur_q;
   assign nxt_ptr  = nxt_q;
   assign halted   = (state == ST_HALT);
   assign ev_chend = (state == ST_CHK) && !owned && ctrl_chie;
   assign ev_fdone = (state == ST_DONE) && cmd_q[CMD_FLAG];

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state)
         ST_RD: begin
            mem_req  = 1'b1;
            mem_addr = desc_word;
         end
         ST_XFER: begin
            if (in_valid && room) begin
               mem_req   = 1'b1;
               mem_we    = 1'b1;
               mem_addr  = buf_q + AW'({scnt_q, 2'b00});
               mem_wdata = in_data;
            end
         end
         ST_WB: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = desc_word;
            case (widx)
               3'd3:    mem_wdata = {CODE_FEND, cmd_q[27:0]};
               3'd4:    mem_wdata = rbytes;
               default: mem_wdata = sbytes;
            endcase
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         widx     <= '0;
         cur_q    <= '0;
         nxt_q    <= '0;
         buf_q    <= '0;
         bwords_q <= '0;
         cmd_q    <= '0;
         rcnt_q   <= '0;
         scnt_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (cur_load) begin
                  cur_q <= cur_wdata;
               end else if (ctrl_en && in_valid) begin
                  widx  <= '0;
                  state <= ST_RD;
               end
            end
            ST_RD: if (mem_gnt) state <= ST_RDW;
            ST_RDW: begin
               case (widx)
                  3'd0:    buf_q    <= mem_rdata[AW-1:0];
                  3'd1:    bwords_q <= mem_rdata[AW-1:2];
                  3'd2:    nxt_q    <= mem_rdata[AW-1:0];
                  default: cmd_q    <= mem_rdata;
               endcase
               if (widx == 3'd3) begin
                  state <= ST_CHK;
               end else begin
                  widx  <= widx + 1'b1;
                  state <= ST_RD;
               end
            end
            ST_CHK: begin
               rcnt_q <= '0;
               scnt_q <= '0;
               state  <= owned ? ST_XFER : ST_HALT;
            end
            ST_XFER: begin
               if (pop) begin
                  rcnt_q <= rcnt_q + 1'b1;
                  if (room) scnt_q <= scnt_q + 1'b1;
                  if (in_last) begin
                     widx  <= 3'd3;
                     state <= ctrl_wb ? ST_WB : ST_DONE;
                  end
               end
            end
            ST_WB: begin
               if (mem_gnt) begin
                  if (widx == 3'd5) state <= ST_DONE;
                  else              widx  <= widx + 1'b1;
               end
            end
            ST_DONE: begin
               cur_q <= nxt_q;
               state <= ST_IDLE;
            end
            ST_HALT: begin
               if (restart) begin
                  cur_q <= nxt_q;
                  state <= ST_IDLE;
               end else if (cur_load) begin
                  cur_q <= cur_wdata;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma #(
   parameter int AW          = 32,
   parameter int STAGE_DEPTH = 16,
   parameter int LEN_W       = 12,
   parameter bit IRQ_REG     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          rx_valid,
   input  logic [31:0]   rx_data,
   input  logic          rx_last,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_gnt,
   input  logic [31:0]   mem_rdata,
   output logic          irq
);
   localparam int SW = 33;

   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("rx_desc_dma: AW must be within 8..32");
      end
      if (LEN_W < 2 || LEN_W >= AW - 2) begin : g_bad_len
         $error("rx_desc_dma: LEN_W must be below AW-2");
      end
   endgenerate

   logic          ctrl_en, ctrl_chie, ctrl_wb, restart, cur_load;
   logic [AW-1:0] cur_ptr, nxt_ptr;
   logic          halted, ovf, err_flag, ev_fdone, ev_chend;
   logic          st_valid, st_pop;
   logic [SW-1:0] st_data;

   rxdr_stage_fifo #(.W(SW), .DEPTH(STAGE_DEPTH)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (rx_valid),
      .in_data   ({rx_last, rx_data}),
      .overflow  (ovf),
      .out_valid (st_valid),
      .out_data  (st_data),
      .pop       (st_pop)
   );

   rxdr_regs #(.AW(AW), .IRQ_REG(IRQ_REG)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .rdata      (reg_rdata),
      .cur_ptr    (cur_ptr),
      .nxt_ptr    (nxt_ptr),
      .ev_fdone   (ev_fdone),
      .ev_chend   (ev_chend),
      .ev_ramfull (ovf),
      .ctrl_en    (ctrl_en),
      .ctrl_chie  (ctrl_chie),
      .ctrl_wb    (ctrl_wb),
      .restart    (restart),
      .cur_load   (cur_load),
      .err_flag   (err_flag),
      .irq        (irq)
   );

   rxdr_engine #(.AW(AW), .LEN_W(LEN_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_en   (ctrl_en),
      .ctrl_chie (ctrl_chie),
      .ctrl_wb   (ctrl_wb),
      .restart   (restart),
      .cur_load  (cur_load),
      .cur_wdata (reg_wdata[AW-1:0]),
      .cur_ptr   (cur_ptr),
      .nxt_ptr   (nxt_ptr),
      .halted    (halted),
      .in_valid  (st_valid),
      .in_data   (st_data[31:0]),
      .in_last   (st_data[32]),
      .pop       (st_pop),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_gnt   (mem_gnt),
      .mem_rdata (mem_rdata),
      .ev_fdone  (ev_fdone),
      .ev_chend  (ev_chend)
   );
endmodule

// File: rtl/rxdr_checker.sv
module rxdr_checker #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_gnt,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          halted,
   input logic          restart,
   input logic          cur_load,
   input logic [AW-1:0] cur_ptr,
   input logic [AW-1:0] nxt_ptr,
   input logic          ovf,
   input logic          err_flag
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10

   AST_HALT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_req); // R2

   AST_HALT_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      halted && !restart && !cur_load |=> $stable(cur_ptr)); // R2

   AST_RESUME_AT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      halted && restart |=> cur_ptr == $past(nxt_ptr)); // R6

   AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> err_flag); // R7
endmodule

bind rx_desc_dma rxdr_checker #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_req  (mem_req),
   .mem_gnt  (mem_gnt),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .halted   (halted),
   .restart  (restart),
   .cur_load (cur_load),
   .cur_ptr  (cur_ptr),
   .nxt_ptr  (nxt_ptr),
   .ovf      (ovf),
   .err_flag (err_flag)
);

// File: tb/rx_desc_dma_tb.sv
module rx_desc_dma_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        rx_valid = 1'b0;
   logic [31:0] rx_data = '0;
   logic        rx_last = 1'b0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_gnt = 1'b1;
   logic [31:0] mem_rdata = '0;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] ram [0:1023];
   logic [31:0] seed_sink;

   always #5 clk = ~clk;

   rx_desc_dma u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_last(rx_last), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
      .mem_rdata(mem_rdata), .irq(irq)
   );

   always @(posedge clk) begin
      if (mem_req && mem_gnt) begin
         if (mem_we) ram[mem_addr[11:2]] <= mem_wdata;
         else        mem_rdata <= ram[mem_addr[11:2]];
      end
   end

   initial begin
      seed_sink = $urandom(32'd2024);
      forever begin
         @(negedge clk);
         mem_gnt = ($urandom % 4) != 0;
      end
   end

   function automatic logic [31:0] fdata(int id, int k);
      return {id[7:0], id[7:0] ^ 8'hA5, 16'(k * 3 + 1)};
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(logic [2:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic send_frame(int id, int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = fdata(id, k); rx_last = (k == n - 1);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
   endtask

   task automatic wait_done(int dw);
      int t = 0;
      while (ram[dw + 3][31:28] != 4'h4 && t < 3000) begin
         @(negedge clk);
         t++;
      end
      repeat (20) @(negedge clk);
   endtask

   task automatic chk_buf(string tag, int bw, int id, int n);
      int bad = 0;
      for (int k = 0; k < n; k++) if (ram[bw + k] !== fdata(id, k)) bad++;
      chk(tag, 32'(bad), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      int n0, n2;
      n0 = 2 + int'($urandom % 9);
      n2 = 2 + int'($urandom % 9);
      for (int i = 0; i < 1024; i++) ram[i] = 32'hDEADBEEF;
      for (int i = 0; i < 4; i++) begin
         ram[i*8 + 0] = 32'h400 + 32'(i) * 32'h100;
         ram[i*8 + 1] = (i == 1) ? 32'd12 : 32'd256;
         ram[i*8 + 2] = 32'(((i + 1) % 4) * 32);
      end
      ram[3]  = 32'hA0800000;
      ram[11] = 32'hA0000000;
      ram[19] = 32'hA0800000;
      ram[27] = 32'h00000000;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      rd_reg(3'd0, v); chk("R12 ctrl reset", v, 0);
      rd_reg(3'd1, v); chk("R12 cur reset", v, 0);
      rd_reg(3'd2, v); chk("R12 nxt reset", v, 0);
      rd_reg(3'd3, v); chk("R12 stat0 reset", v, 0);
      rd_reg(3'd4, v); chk("R12 stat1 reset", v, 0);
      chk("R12 irq reset", 32'(irq), 0);
      wr_reg(3'd1, 32'h40);
      rd_reg(3'd1, v); chk("R12 cur write", v, 32'h40);
      wr_reg(3'd1, 32'h0);

      // R11 disabled engine leaves memory alone
      wr_reg(3'd5, 32'h7);
      wr_reg(3'd0, 32'h00000003);
      send_frame(0, n0);
      repeat (100) @(negedge clk);
      chk("R11 no fetch while disabled", ram[3], 32'hA0800000);
      chk("R11 buffer untouched", ram[256], 32'hDEADBEEF);

      // R1/R3/R4/R5/R8 first frame into D0
      wr_reg(3'd0, 32'h80000003);
      wait_done(0);
      chk_buf("R3 R1 frame0 data", 256, 0, n0);
      chk("R4 D0 status code", ram[3], 32'h40800000);
      chk("R4 D0 result bytes", ram[4], 32'(n0 * 4));
      chk("R4 D0 valid bytes", ram[5], 32'(n0 * 4));
      rd_reg(3'd1, v); chk("R5 cur after D0", v, 32'h20);
      rd_reg(3'd2, v); chk("R5 nxt after D0", v, 32'h20);
      rd_reg(3'd3, v); chk("R8 frame done flagged", v, 32'h1);
      chk("R9 irq on frame done", 32'(irq), 1);
      wr_reg(3'd3, 32'h1);
      @(negedge clk);
      rd_reg(3'd3, v); chk("R9 w1c clears", v, 0);
      chk("R9 irq drops", 32'(irq), 0);

      // R3/R4/R8 truncation into 12-byte D1, unflagged
      send_frame(1, 6);
      wait_done(8);
      chk_buf("R3 frame1 first words", 256 + 64, 1, 3);
      chk("R3 frame1 excess discarded", ram[256 + 64 + 3], 32'hDEADBEEF);
      chk("R4 D1 result bytes", ram[12], 32'd24);
      chk("R4 D1 valid bytes", ram[13], 32'd12);
      rd_reg(3'd3, v); chk("R8 unflagged no done", v, 0);

      // R4 writeback off, R9 masked done
      wr_reg(3'd5, 32'h6);
      wr_reg(3'd0, 32'h80000002);
      send_frame(2, n2);
      repeat (300) @(negedge clk);
      chk_buf("R3 frame2 data", 256 + 128, 2, n2);
      chk("R4 no writeback code", ram[19], 32'hA0800000);
      chk("R4 no writeback size", ram[20], 32'hDEADBEEF);
      rd_reg(3'd3, v); chk("R8 frame2 done", v, 32'h1);
      chk("R9 masked irq", 32'(irq), 0);
      wr_reg(3'd3, 32'h1);

      // R2 halt on software-owned D3
      wr_reg(3'd0, 32'h80000003);
      send_frame(3, 5);
      repeat (100) @(negedge clk);
      rd_reg(3'd3, v); chk("R2 chain end flag", v, 32'h2);
      rd_reg(3'd1, v); chk("R2 cur held", v, 32'h60);
      rd_reg(3'd2, v); chk("R5 nxt of halted", v, 32'h0);
      chk("R2 D3 untouched", ram[27], 32'h0);
      chk("R2 buf3 untouched", ram[256 + 192], 32'hDEADBEEF);
      chk("R9 irq chain end", 32'(irq), 1);

      // R7 staging overflow
      send_frame(4, 12);
      repeat (10) @(negedge clk);
      rd_reg(3'd4, v); chk("R7 ram full flag", v, 32'h2);
      rd_reg(3'd3, v); chk("R7 error summary", v, 32'h6);
      wr_reg(3'd4, 32'h2);
      wr_reg(3'd3, 32'h2);
      @(negedge clk);
      rd_reg(3'd3, v); chk("R9 stat0 cleared", v, 0);

      // R6 resume after the halted descriptor
      ram[27] = 32'hA0800000;
      ram[3]  = 32'hA0800000;
      for (int k = 0; k < 16; k++) ram[256 + k] = 32'hDEADBEEF;
      wr_reg(3'd0, 32'h80000003);
      wait_done(0);
      chk("R6 halted desc not refetched", ram[27], 32'hA0800000);
      chk_buf("R7 held frame delivered", 256, 3, 5);
      chk("R7 held frame bytes", ram[4], 32'd20);
      rd_reg(3'd1, v); chk("R6 cur after resume", v, 32'h20);

      summary();
      $finish;
   end
endmodule